// File: doc/BRIEF.md
# SPI Transaction Engine with Per-Select Modes

This block is the serial core of an SPI master. A single command word starts a transaction: it picks one of four chip selects and gives the number of characters to move, minus one. For the whole transaction the engine uses that chip select's own mode word. The mode word sets the clock idle level, the capture edge, the bit order, the character length, a two-level clock prescaler and the polarity of the select line.

The engine drives SCK, MOSI and the chosen select line, and it samples MISO. It takes characters from an external transmit FIFO and writes each received character into an external receive FIFO. When the transmit FIFO is empty, or the receive FIFO is full, the clock holds with the select still asserted. A global loopback input routes MOSI back into the receive path. A global enable input runs the engine, and clearing it aborts any transfer in flight. A busy level and a one-cycle done pulse report progress to the surrounding event logic.

Top module: `spi_txn_engine`

## Requirements
- R1: A command is accepted only while the engine is idle and enabled. Command bits 31:30 choose the chip select and bits 15:0 give the character count minus one. Exactly that many characters plus one are popped, shifted and pushed.
- R2: Bit 20 of a select's mode word sets that select's active level: 1 means active low, 0 means active high. Every select line sits at its inactive level except the one addressed by a running transaction. That line is asserted from the cycle after acceptance until the last character has been pushed.
- R3: Each SCK half period lasts 2*(PM+1) clock cycles, where PM is mode bits 27:24 and values below 2 count as 2. When mode bit 28 is set, the half period is 16 times longer.
- R4: Mode bit 31 gives the SCK idle level. SCK sits at that level before the first edge of every character, and it does not move while the engine is idle and no command is being accepted.
- R5: With mode bit 30 set, MISO is captured on the leading (first) edge of each bit and MOSI changes on the trailing edge. With bit 30 clear, MOSI changes on the leading edge and MISO is captured on the trailing edge.
- R6: With mode bit 29 set, bits go out and come in most significant first. With it clear, least significant first.
- R7: The character length is mode bits 19:16 plus one, and any value below 4 counts as 4. Transmit characters are taken from the low bits of the transmit word. Received characters are right-aligned, with the upper bits zero.
- R8: With the loopback input high, each received character equals the transmitted one and MISO has no effect. With loopback low, the received bits come from MISO.
- R9: While the transmit FIFO is empty and a character is needed, no pop occurs, SCK does not toggle, and the select stays asserted.
- R10: While the receive FIFO is full, no push occurs and the next character does not start.
- R11: Busy is high from the cycle after acceptance until the transaction ends. Done is high for exactly one cycle per completed transaction, after which busy is low.
- R12: Clearing enable aborts a transaction: busy drops on the next cycle, the select deasserts and no done pulse is given. Commands presented while enable is clear are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baud clock, also the logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Global run enable; clearing it aborts |
| cfg_loop | input | 1 | Route MOSI into the receive path |
| cs_modes | input | NUM_CS*32 | Mode words, select g in bits g*32 +: 32 |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 32 | Select index [31:30], count minus one [15:0] |
| tx_data | input | DATA_W | Head of transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Take the head of the transmit FIFO |
| rx_data | output | DATA_W | Received character, right-aligned |
| rx_push | output | 1 | Write rx_data into the receive FIFO |
| rx_full | input | 1 | Receive FIFO full |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NUM_CS | Select lines, each at its own polarity |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The bench builds the block with its defaults: four selects, 16-bit characters and a 16-bit count field. It therefore reaches every select index and both polarities, character lengths from the clamped minimum of 4 up to 12 bits, and both the divide-by-16 path and the clamp on small PM values. A serial monitor in the bench rebuilds each character from MOSI at the capture edges it derives for itself, and it measures the SCK half periods. The longest counts the field allows are not run, since one such transaction would take millions of cycles.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;

  localparam int MODE_W     = 32;
  localparam int CMD_W      = 32;
  localparam int DIV_W      = 10;
  localparam int CS_POL_BIT = 20;

  typedef struct packed {
    logic       idle_hi;
    logic       cap_first;
    logic       msb_first;
    logic       div16;
    logic [3:0] pm;
    logic       cs_low;
    logic [3:0] len_m1;
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SHIFT,
    ST_PUSH,
    ST_END
  } state_t;

  // Field positions are fixed by the mode word layout.
  function automatic mode_t mode_unpack(input logic [MODE_W-1:0] w);
    mode_t m;
    m.idle_hi   = w[31];
    m.cap_first = w[30];
    m.msb_first = w[29];
    m.div16     = w[28];
    m.pm        = w[27:24];
    m.cs_low    = w[CS_POL_BIT];
    m.len_m1    = w[19:16];
    return m;
  endfunction

  // Clock cycles per SCK half period.
  function automatic logic [DIV_W-1:0] half_cycles(input logic div16, input logic [3:0] pm);
    logic [DIV_W-1:0] pe;
    logic [DIV_W-1:0] h;
    pe = (pm < 4'd2) ? DIV_W'(2) : DIV_W'(pm);
    h  = (pe + DIV_W'(1)) << 1;
    if (div16) h = h << 4;
    return h;
  endfunction

  // Character length in bits, clamped to a minimum of 4.
  function automatic logic [4:0] char_bits(input logic [3:0] len_m1);
    logic [4:0] b;
    b = {1'b0, len_m1} + 5'd1;
    return (b < 5'd4) ? 5'd4 : b;
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || (cnt_q == '0)) begin
      cnt_q <= half_len - DIV_W'(1);
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

endmodule

// File: rtl/spi_char_shift.sv
module spi_char_shift #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int EDGE_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              park_i,
  input  logic              idle_lvl_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic              msb_first_i,
  input  logic              cap_first_i,
  input  logic              edge_i,
  input  logic              ser_in_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              char_done_o
);

  logic [EDGE_W-1:0] edge_q;
  logic [EDGE_W-1:0] edge_m1;
  logic [DATA_W-1:0] tx_q;
  logic [CNT_W-1:0]  drv_idx;
  logic [CNT_W-1:0]  cap_idx;
  logic              cap_evt;

  // Serial position to word lane, honouring bit order.
  function automatic logic [CNT_W-1:0] lane(input logic [CNT_W-1:0] idx,
                                            input logic [CNT_W-1:0] nb,
                                            input logic             msb);
    return msb ? (nb - CNT_W'(1) - idx) : idx;
  endfunction

  assign edge_m1     = edge_q - EDGE_W'(1);
  assign drv_idx     = cap_first_i ? edge_q[EDGE_W-1:1]
                                   : ((edge_q == '0) ? '0 : edge_m1[EDGE_W-1:1]);
  assign cap_idx     = edge_q[EDGE_W-1:1];
  assign cap_evt     = edge_i && (cap_first_i ? ~edge_q[0] : edge_q[0]);
  assign char_done_o = (edge_q == {nbits_i, 1'b0});
  assign mosi_o      = (drv_idx < nbits_i) ? tx_q[lane(drv_idx, nbits_i, msb_first_i)] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q    <= '0;
      sck_o     <= 1'b0;
      tx_q      <= '0;
      rx_word_o <= '0;
    end else if (park_i) begin
      sck_o <= idle_lvl_i;
    end else if (load_i) begin
      edge_q    <= '0;
      sck_o     <= idle_lvl_i;
      tx_q      <= tx_word_i;
      rx_word_o <= '0;
    end else if (edge_i) begin
      edge_q <= edge_q + EDGE_W'(1);
      sck_o  <= ~sck_o;
      if (cap_evt) rx_word_o[lane(cap_idx, nbits_i, msb_first_i)] <= ser_in_i;
    end
  end

endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NUM_CS = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              active_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [NUM_CS-1:0] low_act_i,
  output logic [NUM_CS-1:0] cs_o
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    assign cs_o[g] = (active_i && (sel_i == SEL_W'(g))) ? ~low_act_i[g] : low_act_i[g];
  end

endmodule

// File: rtl/spi_txn_engine.sv
module spi_txn_engine
  import spi_txn_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_enable,
  input  logic                     cfg_loop,
  input  logic [NUM_CS*MODE_W-1:0] cs_modes,
  input  logic                     cmd_valid,
  input  logic [CMD_W-1:0]         cmd_word,
  input  logic [DATA_W-1:0]        tx_data,
  input  logic                     tx_empty,
  output logic                     tx_pop,
  output logic [DATA_W-1:0]        rx_data,
  output logic                     rx_push,
  input  logic                     rx_full,
  output logic                     sck_o,
  output logic                     mosi_o,
  input  logic                     miso_i,
  output logic [NUM_CS-1:0]        cs_o,
  output logic                     busy,
  output logic                     done
);

  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int CNT_W = $clog2(DATA_W + 1);

  state_t             state_q;
  mode_t              cur_mode;
  mode_t              new_mode;
  logic [SEL_W-1:0]   sel_q;
  logic [SEL_W-1:0]   cmd_sel;
  logic [LEN_W-1:0]   left_q;
  logic               start;
  logic               abort;
  logic               park;
  logic               cs_act;
  logic               shift_run;
  logic               tick;
  logic               char_done;
  logic               mosi_int;
  logic               ser_in;
  logic               idle_lvl;
  logic [CNT_W-1:0]   nbits;
  logic [DIV_W-1:0]   half_len;
  logic [NUM_CS-1:0]  low_act;
  logic               unused_bits;

  assign unused_bits = ^{cmd_word, cs_modes};

  // Command decode and event wires
  assign cmd_sel   = cmd_word[CMD_W-1 -: SEL_W];
  assign new_mode  = mode_unpack(cs_modes[cmd_sel*MODE_W +: MODE_W]);
  assign start     = (state_q == ST_IDLE) && cfg_enable && cmd_valid;
  assign abort     = (state_q != ST_IDLE) && !cfg_enable;
  assign park      = start;
  assign cs_act    = (state_q == ST_FETCH) || (state_q == ST_SHIFT) || (state_q == ST_PUSH);
  assign nbits     = CNT_W'(char_bits(cur_mode.len_m1));
  assign half_len  = half_cycles(cur_mode.div16, cur_mode.pm);
  assign shift_run = (state_q == ST_SHIFT) && !char_done && cfg_enable;
  assign idle_lvl  = park ? new_mode.idle_hi : cur_mode.idle_hi;
  assign ser_in    = cfg_loop ? mosi_int : miso_i;

  // FIFO side and status
  assign tx_pop  = (state_q == ST_FETCH) && cfg_enable && !tx_empty;
  assign rx_push = (state_q == ST_PUSH) && cfg_enable && !rx_full;
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_END);
  assign mosi_o  = cs_act ? mosi_int : 1'b0;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_pol
    assign low_act[g] = cs_modes[g*MODE_W + CS_POL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_mode <= '0;
      sel_q    <= '0;
      left_q   <= '0;
    end else if (abort) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          sel_q    <= cmd_sel;
          cur_mode <= new_mode;
          left_q   <= cmd_word[LEN_W-1:0];
          state_q  <= ST_FETCH;
        end
        ST_FETCH: if (!tx_empty) state_q <= ST_SHIFT;
        ST_SHIFT: if (char_done) state_q <= ST_PUSH;
        ST_PUSH: if (!rx_full) begin
          if (left_q == '0) begin
            state_q <= ST_END;
          end else begin
            left_q  <= left_q - LEN_W'(1);
            state_q <= ST_FETCH;
          end
        end
        ST_END:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  spi_clk_div #(.DIV_W(DIV_W)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (shift_run),
    .half_len (half_len),
    .tick     (tick)
  );

  spi_char_shift #(.DATA_W(DATA_W)) shf_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .park_i      (park),
    .idle_lvl_i  (idle_lvl),
    .load_i      (tx_pop),
    .tx_word_i   (tx_data),
    .nbits_i     (nbits),
    .msb_first_i (cur_mode.msb_first),
    .cap_first_i (cur_mode.cap_first),
    .edge_i      (tick),
    .ser_in_i    (ser_in),
    .sck_o       (sck_o),
    .mosi_o      (mosi_int),
    .rx_word_o   (rx_data),
    .char_done_o (char_done)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS)) csd_i (
    .active_i  (cs_act),
    .sel_i     (sel_q),
    .low_act_i (low_act),
    .cs_o      (cs_o)
  );

endmodule

// File: rtl/spi_txn_engine_chk.sv
module spi_txn_engine_chk #(
  parameter int NUM_CS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_enable,
  input logic [NUM_CS*32-1:0] cs_modes,
  input logic                cmd_valid,
  input logic                tx_empty,
  input logic                tx_pop,
  input logic                rx_full,
  input logic                rx_push,
  input logic                sck_o,
  input logic [NUM_CS-1:0]   cs_o,
  input logic                busy,
  input logic                done
);

  logic [NUM_CS-1:0] line_on;
  logic              chk_unused;

  assign chk_unused = ^cs_modes;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_on
    assign line_on[g] = (cs_o[g] != cs_modes[g*32 + 20]);
  end

  p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_on));

  p_select_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (line_on == '0));

  p_pop_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> busy);

  p_sck_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && cfg_enable)) |=> $stable(sck_o));

  p_pop_has_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  p_push_has_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_enable) |=> !busy);

  p_ignore_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_enable) |=> !busy);

endmodule

bind spi_txn_engine spi_txn_engine_chk #(.NUM_CS(NUM_CS)) chk_i (.*);

// File: tb/spi_txn_engine_tb_top.sv
`timescale 1ns/1ps
module spi_txn_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_loop = 1'b0;
  logic [127:0] cs_modes = '0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [15:0] tx_data;
  logic        tx_empty;
  logic        tx_pop;
  logic [15:0] rx_data;
  logic        rx_push;
  logic        rx_full = 1'b0;
  logic        sck_o, mosi_o;
  logic        miso_i = 1'b0;
  logic [3:0]  cs_o;
  logic        busy, done;

  int checks = 0, errors = 0;
  bit finished = 0;

  // FIFO models
  logic [15:0] txq [0:15];
  logic [15:0] rxq [0:15];
  int tx_n = 0, tx_rd = 0, rx_n = 0, done_n = 0;

  // Serial monitor
  bit          mon_arm = 0;
  bit          m_idle = 0, m_cap = 1;
  int          m_bits = 8;
  int          edges = 0, nb = 0, mon_n = 0;
  logic [15:0] ser = '0;
  logic [15:0] mon [0:15];
  time         last_t = 0, min_gap = 0;

  always #5 clk = ~clk;

  spi_txn_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_loop(cfg_loop),
    .cs_modes(cs_modes), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_push(rx_push), .rx_full(rx_full),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o),
    .busy(busy), .done(done)
  );

  assign tx_data  = txq[tx_rd[3:0]];
  assign tx_empty = (tx_rd >= tx_n);

  always @(posedge clk) begin
    if (tx_pop) tx_rd <= tx_rd + 1;
    if (rx_push) begin
      rxq[rx_n[3:0]] <= rx_data;
      rx_n <= rx_n + 1;
    end
    if (done) done_n <= done_n + 1;
  end

  always @(sck_o) begin
    if (mon_arm) begin
      edges = edges + 1;
      if (last_t != 0 && ($time - last_t) < min_gap) min_gap = $time - last_t;
      last_t = $time;
      if ((sck_o != m_idle) == m_cap) begin
        ser = {ser[14:0], mosi_o};
        nb = nb + 1;
        if (nb == m_bits) begin
          mon[mon_n[3:0]] = ser;
          mon_n = mon_n + 1;
          nb = 0;
          ser = '0;
        end
      end
    end
  end

  function automatic logic [31:0] make_mode(bit idle, bit capf, bit msb, bit d16,
                                            logic [3:0] pm, bit cslow, logic [3:0] lm1);
    logic [31:0] w = '0;
    w[31] = idle; w[30] = capf; w[29] = msb; w[28] = d16;
    w[27:24] = pm; w[20] = cslow; w[19:16] = lm1;
    return w;
  endfunction

  function automatic logic [15:0] rev_bits(logic [15:0] v, int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = v[n-1-i];
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    tx_rd = 0; rx_n = 0; done_n = 0; mon_n = 0; edges = 0; nb = 0; ser = '0;
    last_t = 0; min_gap = 1000000;
  endtask

  task automatic start_cmd(int sel, int cnt_m1, bit idle, bit capf, int bits);
    @(negedge clk);
    mon_arm = 0;
    clear_counts();
    m_idle = idle; m_cap = capf; m_bits = bits;
    cmd_word = {sel[1:0], 14'd0, cnt_m1[15:0]};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    mon_arm = 1;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, req, "transaction ended", busy, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(busy == 0, "R11", "busy after reset", busy, 0);
    chk(done == 0, "R11", "done after reset", done, 0);
    chk(cs_o == 4'b0101, "R2", "select lines after reset", cs_o, 4'b0101);
    chk(sck_o == 0 && tx_pop == 0 && rx_push == 0, "R4", "sck/pop/push after reset",
        {sck_o, tx_pop, rx_push}, 0);
  endtask

  task automatic t_basic();
    txq[0] = 16'h00A5; txq[1] = 16'h003C; txq[2] = 16'h00F0; tx_n = 3;
    cfg_loop = 1;
    cs_modes[64 +: 32] = make_mode(0, 1, 1, 0, 4'd2, 1, 4'd7);
    start_cmd(2, 2, 0, 1, 8);
    repeat (5) @(negedge clk);
    chk(cs_o == 4'b0001, "R1", "only select 2 asserted", cs_o, 4'b0001);
    chk(busy == 1, "R11", "busy during transfer", busy, 1);
    wait_idle("R1");
    chk(tx_rd == 3 && rx_n == 3, "R1", "pops and pushes for count 2", {tx_rd, rx_n}, 'h0000000300000003);
    for (int i = 0; i < 3; i++) begin
      chk(rxq[i] == txq[i], "R8", "loopback character", rxq[i], txq[i]);
      chk(mon[i] == txq[i], "R6", "msb-first serial character", mon[i], txq[i]);
    end
    chk(min_gap == 60, "R3", "half period PM=2", min_gap, 60);
    chk(edges == 48, "R5", "edge count 3x8 bits", edges, 48);
    chk(done_n == 1, "R11", "single done pulse", done_n, 1);
    chk(cs_o == 4'b0101 && sck_o == 0, "R2", "select released, sck idle", {cs_o, sck_o}, 'hA);
  endtask

  task automatic t_lsb();
    txq[0] = 16'h0ABC; tx_n = 1;
    cfg_loop = 1;
    cs_modes[32 +: 32] = make_mode(1, 0, 0, 0, 4'd0, 0, 4'd11);
    start_cmd(1, 0, 1, 0, 12);
    repeat (3) @(negedge clk);
    chk(cs_o == 4'b0111, "R2", "active-high select 1 asserted", cs_o, 4'b0111);
    wait_idle("R5");
    chk(mon[0] == rev_bits(16'h0ABC, 12), "R6", "lsb-first trailing-edge order", mon[0], rev_bits(16'h0ABC, 12));
    chk(rxq[0] == 16'h0ABC, "R7", "12-bit loopback right-aligned", rxq[0], 16'h0ABC);
    chk(sck_o == 1, "R4", "sck idles high", sck_o, 1);
    chk(edges == 24, "R7", "edges for 12 bits", edges, 24);
    chk(min_gap == 60, "R3", "PM=0 clamped to 2", min_gap, 60);
  endtask

  task automatic t_div();
    txq[0] = 16'h001B; tx_n = 1;
    cfg_loop = 1;
    cs_modes[96 +: 32] = make_mode(0, 1, 1, 1, 4'd3, 0, 4'd1);
    start_cmd(3, 0, 0, 1, 4);
    wait_idle("R3");
    chk(min_gap == 1280, "R3", "half period with divide-by-16", min_gap, 1280);
    chk(edges == 8, "R7", "length clamped to 4 bits", edges, 8);
    chk(rxq[0] == 16'h000B, "R7", "4-bit character masked", rxq[0], 16'h000B);
    chk(mon[0] == 16'h000B, "R6", "4-bit serial data", mon[0], 16'h000B);
  endtask

  task automatic t_miso();
    cs_modes[0 +: 32] = make_mode(0, 1, 1, 0, 4'd2, 1, 4'd5);
    txq[0] = 16'h0000; tx_n = 1;
    cfg_loop = 0; miso_i = 1;
    start_cmd(0, 0, 0, 1, 6);
    wait_idle("R8");
    chk(rxq[0] == 16'h003F, "R8", "bits taken from MISO", rxq[0], 16'h003F);
    txq[0] = 16'h0015; tx_n = 1;
    cfg_loop = 1; miso_i = 1;
    start_cmd(0, 0, 0, 1, 6);
    wait_idle("R8");
    chk(rxq[0] == 16'h0015, "R8", "MISO ignored in loopback", rxq[0], 16'h0015);
    miso_i = 0;
  endtask

  task automatic t_tx_stall();
    txq[0] = 16'h0081; txq[1] = 16'h0042; tx_n = 1;
    cfg_loop = 1;
    start_cmd(2, 1, 0, 1, 8);
    repeat (300) @(negedge clk);
    chk(edges == 16 && rx_n == 1, "R9", "clock stops when tx empty", edges, 16);
    chk(busy == 1 && cs_o == 4'b0001, "R9", "select held during stall", cs_o, 4'b0001);
    tx_n = 2;
    wait_idle("R9");
    chk(rx_n == 2 && rxq[1] == 16'h0042, "R9", "resumes after refill", rxq[1], 16'h0042);
    chk(done_n == 1, "R11", "done after stalled transfer", done_n, 1);
  endtask

  task automatic t_rx_stall();
    txq[0] = 16'h0011; txq[1] = 16'h00EE; tx_n = 2;
    cfg_loop = 1; rx_full = 1;
    start_cmd(2, 1, 0, 1, 8);
    repeat (400) @(negedge clk);
    chk(edges == 16 && rx_n == 0 && tx_rd == 1, "R10", "no push or next character while full",
        edges, 16);
    rx_full = 0;
    wait_idle("R10");
    chk(rx_n == 2 && rxq[0] == 16'h0011 && rxq[1] == 16'h00EE, "R10", "data after release",
        rxq[1], 16'h00EE);
  endtask

  task automatic t_abort();
    for (int i = 0; i < 4; i++) txq[i] = 16'(i + 1);
    tx_n = 4; cfg_loop = 1;
    start_cmd(2, 3, 0, 1, 8);
    repeat (150) @(negedge clk);
    cfg_enable = 0;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 0 && cs_o == 4'b0101, "R12", "abort releases select", {busy, cs_o}, 'h5);
    chk(done_n == 0, "R12", "no done on abort", done_n, 0);
    start_cmd(2, 0, 0, 1, 8);
    repeat (3) @(negedge clk);
    chk(busy == 0 && tx_rd == 0, "R12", "command ignored while disabled", {busy, tx_rd[3:0]}, 0);
    cfg_enable = 1;
    txq[0] = 16'h005A; tx_n = 1;
    start_cmd(2, 0, 0, 1, 8);
    wait_idle("R12");
    chk(rxq[0] == 16'h005A && done_n == 1, "R12", "runs again after re-enable", rxq[0], 16'h005A);
  endtask

  initial begin
    cs_modes[0 +: 32]  = make_mode(0, 1, 1, 0, 4'd2, 1, 4'd7);
    cs_modes[32 +: 32] = make_mode(0, 1, 1, 0, 4'd2, 0, 4'd7);
    cs_modes[64 +: 32] = make_mode(0, 1, 1, 0, 4'd2, 1, 4'd7);
    cs_modes[96 +: 32] = make_mode(0, 1, 1, 0, 4'd2, 0, 4'd7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    cfg_enable = 1;
    t_basic();
    t_lsb();
    t_div();
    t_miso();
    t_tx_stall();
    t_rx_stall();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule